// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns a 20-bit word address issued by a program into a 16-bit word address in main memory. Memory is split into pages of 2048 words: the top 9 address bits name one of 512 virtual pages, and the low 11 bits give the word within the page. Main memory holds 32 page frames, so a translated address is a 5-bit frame number with the unchanged 11-bit offset below it.

An 8-entry, fully associative translation cache holds recent mappings and is searched first. On a miss, the block reads the page descriptor from an in-memory page table. The table is read through a request port whose data arrives one cycle after the request. A present descriptor is then installed in the cache, and the lookup repeats.

Each descriptor carries a frame number, a present flag, a modified flag and a write-permission flag. A write that is allowed marks the cached copy modified, and the updated descriptor is sent out so that software can keep the table in step. Software can drop a cached mapping with an invalidate command.

Top module: `vat_tlb`

## Requirements
- R1: A successful translation returns `rsp_paddr` equal to the 5-bit frame number in bits 15:11 and the request's offset (bits 10:0 of `req_vaddr`) in bits 10:0, with `rsp_status` = 2'b00.
- R2: A request whose page is held in the cache responds in the second cycle after acceptance with `rsp_tlb_hit` = 1 and issues no page-table read.
- R3: On a cache miss, the block raises `pt_req_valid` for one cycle with `pt_req_index` equal to the virtual page number (`req_vaddr[19:11]`). It samples `pt_rsp_data` in the following cycle and responds with `rsp_tlb_hit` = 0. Descriptor layout: bits 4:0 frame, bit 5 present, bit 6 modified, bit 7 writable.
- R4: If the fetched descriptor has its present bit clear, the response has `rsp_status` = 2'b01 (fault) and `rsp_paddr` = 0, and the page is not installed in the cache.
- R5: A write (`req_write` = 1) to a page whose writable bit is 0 responds with `rsp_status` = 2'b10 (violation) and `rsp_paddr` = 0, and sends no write-back. Reads of such a page translate normally.
- R6: A permitted write to a page whose modified bit is clear sets that bit in the cache. In the same cycle as the response, it pulses `wb_valid` with `wb_index` = page number and `wb_data` = the descriptor with the modified bit set. A write to a page already modified sends no write-back.
- R7: A cycle with `inv_valid` = 1 removes any cache entry whose page equals `inv_vpn`, so the next access to that page misses.
- R8: A new mapping goes into the lowest-numbered empty cache entry if one exists. Otherwise it goes into the entry named by a round-robin pointer, which starts at 0 and advances by one each time it is used.
- R9: `req_ready` is high only while no translation is in progress. `rsp_valid` is a one-cycle pulse for each accepted request.
- R10: After reset the cache is empty, `req_ready` = 1, and `rsp_valid`, `pt_req_valid` and `wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 20 | Virtual word address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 16 | Physical word address (0 unless status is OK) |
| rsp_status | output | 2 | 00 OK, 01 fault, 10 violation |
| rsp_tlb_hit | output | 1 | Translation came from the cache without a table read |
| pt_req_valid | output | 1 | Page-table read request |
| pt_req_index | output | 9 | Page-table index (virtual page number) |
| pt_rsp_data | input | 8 | Descriptor, valid the cycle after the request |
| wb_valid | output | 1 | Updated descriptor available |
| wb_index | output | 9 | Page-table index to update |
| wb_data | output | 8 | Updated descriptor |
| inv_valid | input | 1 | Invalidate command |
| inv_vpn | input | 9 | Page to invalidate |

## Verification
The hardest states to reach are a full cache, where the round-robin victim choice decides which of eight older mappings survives, and a cache holding a hole left by an invalidate. The bench keeps its own copy of the eight tags, valid flags and pointer. It drives every page once and then a long pseudo-random stream of reads, writes and invalidates over a small set of pages, so that evictions happen constantly. Every response's hit flag is then checked against the model's prediction. Writes are repeated so that both the first-write write-back and the silent second write are seen.

// File: rtl/vat_tlb.sv
module vat_tlb #(
  parameter int VA_W    = 20,
  parameter int OFF_W   = 11,
  parameter int FRAME_W = 5,
  parameter int ENTRIES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VA_W-1:0]          req_vaddr,
  input  logic                     req_write,
  output logic                     rsp_valid,
  output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
  output logic [1:0]               rsp_status,
  output logic                     rsp_tlb_hit,
  output logic                     pt_req_valid,
  output logic [VA_W-OFF_W-1:0]    pt_req_index,
  input  logic [FRAME_W+2:0]       pt_rsp_data,
  output logic                     wb_valid,
  output logic [VA_W-OFF_W-1:0]    wb_index,
  output logic [FRAME_W+2:0]       wb_data,
  input  logic                     inv_valid,
  input  logic [VA_W-OFF_W-1:0]    inv_vpn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = FRAME_W + OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int P_BIT = FRAME_W;
  localparam int W_BIT = FRAME_W + 2;

  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_WAIT} state_t;
  state_t state;

  logic [VPN_W-1:0]   t_vpn   [ENTRIES];
  logic [FRAME_W-1:0] t_frame [ENTRIES];
  logic [ENTRIES-1:0] t_v, t_d, t_w, hit_vec;
  logic [IDX_W-1:0]   hit_idx, vic, rr;
  logic [VPN_W-1:0]   cur_vpn;
  logic [OFF_W-1:0]   cur_off;
  logic               cur_wr, cur_missed;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit_vec[i] = t_v[i] && (t_vpn[i] == cur_vpn);
  end

  always_comb begin
    hit_idx = '0;
    vic     = rr;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!t_v[i]) vic = IDX_W'(i);
  end

  wire hit_any = |hit_vec;
  wire use_rr  = &t_v;

  assign req_ready    = (state == S_IDLE);
  assign pt_req_valid = (state == S_LOOK) && !hit_any;
  assign pt_req_index = cur_vpn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      t_v         <= '0;
      rr          <= '0;
      rsp_valid   <= 1'b0;
      wb_valid    <= 1'b0;
      rsp_paddr   <= '0;
      rsp_status  <= 2'b00;
      rsp_tlb_hit <= 1'b0;
      cur_missed  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      wb_valid  <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          cur_vpn    <= req_vaddr[VA_W-1:OFF_W];
          cur_off    <= req_vaddr[OFF_W-1:0];
          cur_wr     <= req_write;
          cur_missed <= 1'b0;
          state      <= S_LOOK;
        end
        S_LOOK: if (hit_any) begin
          rsp_valid   <= 1'b1;
          rsp_tlb_hit <= !cur_missed;
          state       <= S_IDLE;
          if (cur_wr && !t_w[hit_idx]) begin
            rsp_status <= 2'b10;
            rsp_paddr  <= '0;
          end else begin
            rsp_status <= 2'b00;
            rsp_paddr  <= {t_frame[hit_idx], cur_off};
            if (cur_wr && !t_d[hit_idx]) begin
              t_d[hit_idx] <= 1'b1;
              wb_valid     <= 1'b1;
              wb_index     <= cur_vpn;
              wb_data      <= {3'b111, t_frame[hit_idx]};
            end
          end
        end else begin
          state <= S_WAIT;
        end
        S_WAIT: begin
          cur_missed <= 1'b1;
          if (!pt_rsp_data[P_BIT]) begin
            rsp_valid   <= 1'b1;
            rsp_tlb_hit <= 1'b0;
            rsp_status  <= 2'b01;
            rsp_paddr   <= '0;
            state       <= S_IDLE;
          end else begin
            t_vpn[vic]   <= cur_vpn;
            t_frame[vic] <= pt_rsp_data[FRAME_W-1:0];
            t_d[vic]     <= pt_rsp_data[P_BIT+1];
            t_w[vic]     <= pt_rsp_data[W_BIT];
            t_v[vic]     <= !(inv_valid && inv_vpn == cur_vpn);
            if (use_rr) rr <= rr + 1'b1;
            state <= S_LOOK;
          end
        end
        default: state <= S_IDLE;
      endcase
      for (int i = 0; i < ENTRIES; i++)
        if (inv_valid && t_vpn[i] == inv_vpn) t_v[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/vat_tlb_chk.sv
module vat_tlb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic [15:0] rsp_paddr,
  input logic [1:0]  rsp_status,
  input logic        rsp_tlb_hit,
  input logic        pt_req_valid,
  input logic        wb_valid
);
  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r9_busy_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req_valid |-> !req_ready);
  a_r3_fetch_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req_valid |=> !req_ready && !pt_req_valid);
  a_r4_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'b01) |-> (rsp_paddr == 16'h0 && !rsp_tlb_hit));
  a_r5_viol_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'b10) |-> (rsp_paddr == 16'h0 && !wb_valid));
  a_r6_wb_with_ok: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (rsp_valid && rsp_status == 2'b00));
  a_r1_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'b11);
endmodule

bind vat_tlb vat_tlb_chk u_chk (.*);

// File: tb/test_vat_tlb.sv
`timescale 1ns/1ps
module test_vat_tlb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, inv_valid = 0;
  logic [19:0] req_vaddr = '0;
  logic [8:0]  inv_vpn = '0;
  logic req_ready, rsp_valid, rsp_tlb_hit, pt_req_valid, wb_valid;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_status;
  logic [8:0]  pt_req_index, wb_index;
  logic [7:0]  pt_rsp_data = '0, wb_data;

  always #2 clk = ~clk;

  vat_tlb i_vat_tlb (.*);

  logic [7:0] mem [512];
  always @(posedge clk) begin
    if (pt_req_valid) pt_rsp_data <= mem[pt_req_index];
    if (wb_valid) mem[wb_index] <= wb_data;
  end

  int tests = 0, fails = 0;
  bit exp_d [512];
  int m_vpn [8];
  bit m_v [8];
  int m_rr = 0;

  function automatic logic [4:0] frm(int v); return 5'((v * 7 + 3) % 32); endfunction
  function automatic bit pres(int v); return (v % 5) != 0; endfunction
  function automatic bit wrt(int v); return (v % 3) != 0; endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(int vpn, int off, bit wr);
    bit mh = 0, saw_pt = 0, got = 0, e_wb;
    int pt_idx = -1, slot;
    logic [1:0] e_st;
    logic [15:0] e_pa;
    for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == vpn) mh = 1;
    if (!mh && pres(vpn)) begin
      slot = -1;
      for (int i = 7; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % 8; end
      m_v[slot] = 1; m_vpn[slot] = vpn;
    end
    if (!pres(vpn)) begin e_st = 2'b01; e_pa = 0; end
    else if (wr && !wrt(vpn)) begin e_st = 2'b10; e_pa = 0; end
    else begin e_st = 2'b00; e_pa = {frm(vpn), 11'(off)}; end
    e_wb = (e_st == 2'b00) && wr && !exp_d[vpn];
    if (e_wb) exp_d[vpn] = 1;

    @(negedge clk);
    req_valid = 1; req_write = wr; req_vaddr = {9'(vpn), 11'(off)};
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R9", "ready while busy", req_ready, 0);
    for (int n = 0; n < 8 && !got; n++) begin
      if (pt_req_valid) begin saw_pt = 1; pt_idx = pt_req_index; end
      if (rsp_valid) begin
        got = 1;
        chk(rsp_status == e_st, e_st == 2'b01 ? "R4" : (e_st == 2'b10 ? "R5" : "R1"),
            "status", rsp_status, e_st);
        chk(rsp_paddr == e_pa, "R1", "paddr", rsp_paddr, e_pa);
        chk(rsp_tlb_hit == mh, "R8", "tlb hit flag", rsp_tlb_hit, mh);
        chk(wb_valid == e_wb, "R6", "writeback pulse", wb_valid, e_wb);
        if (e_wb) chk(wb_index == 9'(vpn) && wb_data == {3'b111, frm(vpn)}, "R6",
                      "writeback data", {wb_index, wb_data}, {9'(vpn), 3'b111, frm(vpn)});
        if (mh) chk(n == 1, "R2", "hit latency", n, 1);
      end else @(negedge clk);
    end
    chk(got, "R9", "response seen", got, 1);
    chk(saw_pt == !mh, mh ? "R2" : "R3", "table read issued", saw_pt, !mh);
    if (saw_pt) chk(pt_idx == vpn, "R3", "table index", pt_idx, vpn);
    @(negedge clk);
    chk(rsp_valid == 0, "R9", "response one cycle", rsp_valid, 0);
  endtask

  task automatic inval(int vpn);
    @(negedge clk);
    inv_valid = 1; inv_vpn = 9'(vpn);
    @(negedge clk);
    inv_valid = 0;
    for (int i = 0; i < 8; i++) if (m_vpn[i] == vpn) m_v[i] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed = 12345;
    for (int v = 0; v < 512; v++) begin
      mem[v] = {wrt(v), 1'b0, pres(v), frm(v)};
      exp_d[v] = 0;
    end
    for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_vpn[i] = -1; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && pt_req_valid == 0 && wb_valid == 0,
        "R10", "reset outputs", {req_ready, rsp_valid, pt_req_valid, wb_valid}, 4'b1000);
    rst_n = 1;
    // R1 R3 R4: every page, each read twice (second read hits when present, R2)
    for (int v = 0; v < 512; v++) begin
      access(v, (v * 37) % 2048, 0);
      access(v, 2047 - v, 0);
    end
    // R5 R6: writes twice on a block of pages
    for (int v = 0; v < 48; v++) begin
      access(v, v, 1);
      access(v, v + 1, 1);
      access(v, 0, 0);
    end
    // R7: invalidate drops mapping; R8: hole refilled first
    access(100 + 1, 5, 0);
    inval(101);
    access(101, 6, 0);
    inval(9999 % 512);
    access(101, 7, 0);
    // R8 R7 mixed stream over 16 pages
    for (int k = 0; k < 3000; k++) begin
      int v, op;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      v = 200 + ((seed >> 8) % 16);
      op = (seed >> 4) % 8;
      if (op == 0) inval(v);
      else access(v, (seed >> 12) % 2048, op == 1);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule